// File: doc/BRIEF.md
# Time-Multiplexed Track Segment Finder

The block searches the hit pattern of one drift-chamber superlayer for track segments. The superlayer is a group of cells, and each cell has 12 wire planes. Each wire reports two hit flags, prompt and delayed. A fixed table of segment masks lists, for every plane, the hit type a segment needs and which cell the wire belongs to (the cell itself or its outer neighbour). A mask matches when no more than a programmable number of its planes lack the required hit. Every matching mask lights its pixel. The block reports every lit pixel, not only the best segment.

Four adjacent cells share one copy of the comparison logic. On a crossing strobe the block captures the whole hit image and the tolerance. It then evaluates the cells one per clock, in the fixed order 0 to 3. The four 12-bit results go out together on the next strobe. The mode is set by a parameter:

- **Inner mode:** the result word is 12 position pixels.
- **Outer mode:** the result word is 6 pixels with a 2-bit slope class each.

Top module: `seg_finder`

## Requirements
- R1: Reset clears `seg_out` to zero. The first strobe after reset also presents zero, because no crossing has been evaluated yet.
- R2: A mask matches a cell when the number of its 12 planes whose required hit flag is absent is at most the captured tolerance (0 to 3). With one more absent plane, the mask does not match.
- R3: Each cell supplies plane j as a 2-bit field at `hits[(cell*12+j)*2 +: 2]`, with bit 0 = prompt and bit 1 = delayed. There are NCELL+1 cells; the last one only serves as a neighbour. Mask entry m occupies `MASKS[m*30 +: 30]`, laid out as follows:
  - bits [2j+1:2j] are {neighbour, type} for plane j. Type 0 requires prompt and type 1 requires delayed. Neighbour 1 reads cell c+1 instead of cell c.
  - bits [27:24] are the pixel index.
  - bits [29:28] are the slope class.
- R4: In inner mode, bit p of a cell's word is the OR of all matching masks with pixel index p. Bits that no matching mask names stay 0.
- R5: All matching masks are reported together. Several pixels of one cell can be set in the same crossing.
- R6: In outer mode, pixel p of a cell occupies bits [2p+1:2p]. The codes are 00 (none), 01 (negative, low momentum), 10 (positive, low momentum) and 11 (high momentum). When several matching masks share a pixel, the code with priority 11 > 10 > 01 wins.
- R7: The word of cell c sits at `seg_out[c*12 +: 12]`. All cells are evaluated from the hit image and tolerance captured at the strobe. Changes on `hits` and `tol` between strobes have no effect.
- R8: The result of a crossing appears on `seg_out` at the clock edge of the next strobe and holds until the strobe after that. Strobes must be at least NCELL+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xing | input | 1 | Crossing strobe, one cycle wide |
| tol | input | 2 | Allowed number of missing planes |
| hits | input | (NCELL+1)*24 | Prompt/delayed flags per cell and plane |
| seg_out | output | NCELL*12 | Per-cell pixel words of the previous crossing |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Tolerance boundary.** Exactly as many absent planes as the tolerance must match, and one more must not. An off-by-one comparison flips a pixel.
- **Neighbour-cell planes.** Some planes read the neighbour cell, including the spare fifth cell. A slot-index mistake reads the wrong cell.
- **Overlapping masks in outer mode.** Masks of different classes that share a pixel catch a design that lets the last mask win instead of the highest class.
- **Scrambled inputs after the strobe.** `hits` and `tol` are changed after each strobe. A design that does not snapshot its inputs then produces results that mix two crossings.

// File: rtl/seg_finder.sv
module seg_finder #(
  parameter int NCELL  = 4,
  parameter int NPLANE = 12,
  parameter int NMASK  = 8,
  parameter bit OUTER  = 1'b0,
  parameter int MW     = 2*NPLANE + 6,
  parameter logic [NMASK*MW-1:0] MASKS = '0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          xing,
  input  logic [1:0]                    tol,
  input  logic [(NCELL+1)*NPLANE*2-1:0] hits,
  output logic [NCELL*12-1:0]           seg_out
);
  localparam int HW = (NCELL+1)*NPLANE*2;
  localparam int SW = (NCELL > 1) ? $clog2(NCELL) : 1;
  localparam int NPIX = OUTER ? 6 : 12;

  logic [HW-1:0]       snap;
  logic [1:0]          tol_q;
  logic [SW-1:0]       slot;
  logic                run;
  logic [NCELL*12-1:0] stage;
  logic [11:0]         cell_res;

  always_comb begin
    cell_res = '0;
    for (int m = 0; m < NMASK; m++) begin
      int miss;
      int pix;
      logic [1:0] slp;
      miss = 0;
      for (int j = 0; j < NPLANE; j++) begin
        int c;
        c = int'(slot) + int'(MASKS[m*MW + 2*j + 1]);
        if (!snap[(c*NPLANE + j)*2 + int'(MASKS[m*MW + 2*j])]) miss++;
      end
      pix = int'(MASKS[m*MW + 2*NPLANE +: 4]);
      slp = MASKS[m*MW + 2*NPLANE + 4 +: 2];
      if (miss <= int'(tol_q) && pix < NPIX) begin
        if (OUTER) begin
          if (slp > cell_res[2*pix +: 2]) cell_res[2*pix +: 2] = slp;
        end else begin
          cell_res[pix] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap    <= '0;
      tol_q   <= '0;
      slot    <= '0;
      run     <= 1'b0;
      stage   <= '0;
      seg_out <= '0;
    end else if (xing) begin
      seg_out <= stage;
      snap    <= hits;
      tol_q   <= tol;
      slot    <= '0;
      run     <= 1'b1;
    end else if (run) begin
      stage[int'(slot)*12 +: 12] <= cell_res;
      slot <= slot + 1'b1;
      if (slot == SW'(NCELL-1)) run <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> seg_out == '0);
  // R8
  hold_between_xing_chk: assert property (@(posedge clk) disable iff (rst)
    !xing |=> $stable(seg_out));
  // R7
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    xing |=> (run && slot == '0));
  // R8
  xing_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> !xing);
endmodule

// File: tb/tb_seg_finder.sv
module tb_seg_finder;
  localparam int NC = 4, NP = 12, NM = 8, MWB = 30, HWB = (NC+1)*NP*2;

  localparam logic [11:0] TYP [NM] = '{12'h000, 12'hFFF, 12'hAAA, 12'h0F0,
                                       12'h001, 12'hFFF, 12'h555, 12'hC3C};
  localparam logic [11:0] SEL [NM] = '{12'h000, 12'h000, 12'h000, 12'hF00,
                                       12'h000, 12'h00F, 12'h000, 12'h003};
  localparam int PIX [NM] = '{0, 0, 3, 5, 1, 4, 3, 2};
  localparam logic [1:0] SLP [NM] = '{2'b01, 2'b11, 2'b10, 2'b01,
                                      2'b10, 2'b10, 2'b01, 2'b11};

  function automatic logic [NM*MWB-1:0] pack_tbl();
    logic [NM*MWB-1:0] t;
    t = '0;
    for (int m = 0; m < NM; m++) begin
      for (int j = 0; j < NP; j++) begin
        t[m*MWB + 2*j]     = TYP[m][j];
        t[m*MWB + 2*j + 1] = SEL[m][j];
      end
      t[m*MWB + 24 +: 4] = 4'(PIX[m]);
      t[m*MWB + 28 +: 2] = SLP[m];
    end
    return t;
  endfunction
  localparam logic [NM*MWB-1:0] TBL = pack_tbl();

  logic clk = 0, rst = 1, xing = 0;
  logic [1:0] tol = 0;
  logic [HWB-1:0] hits = '0;
  logic [NC*12-1:0] out_i, out_o;

  seg_finder #(.NCELL(NC), .NPLANE(NP), .NMASK(NM), .OUTER(1'b0), .MASKS(TBL)) dut (
    .clk(clk), .rst(rst), .xing(xing), .tol(tol), .hits(hits), .seg_out(out_i));
  seg_finder #(.NCELL(NC), .NPLANE(NP), .NMASK(NM), .OUTER(1'b1), .MASKS(TBL)) dut_o (
    .clk(clk), .rst(rst), .xing(xing), .tol(tol), .hits(hits), .seg_out(out_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [NC*12-1:0] exp_i = '0, exp_o = '0, nxt_i = '0, nxt_o = '0;
  string tag_cur = "R1", tag_nxt = "R1";

  function automatic logic [NC*12-1:0] model(input logic [HWB-1:0] h, input int t, input bit outer);
    logic [NC*12-1:0] r;
    r = '0;
    for (int c = 0; c < NC; c++)
      for (int m = 0; m < NM; m++) begin
        int miss;
        miss = 0;
        for (int j = 0; j < NP; j++)
          if (!h[((c + int'(SEL[m][j]))*NP + j)*2 + int'(TYP[m][j])]) miss++;
        if (miss <= t) begin
          if (outer) begin
            if (SLP[m] > r[c*12 + 2*PIX[m] +: 2]) r[c*12 + 2*PIX[m] +: 2] = SLP[m];
          end else r[c*12 + PIX[m]] = 1'b1;
        end
      end
    return r;
  endfunction

  function automatic logic [HWB-1:0] put(input logic [HWB-1:0] h, input int c, input int m);
    for (int j = 0; j < NP; j++)
      h[((c + int'(SEL[m][j]))*NP + j)*2 + int'(TYP[m][j])] = 1'b1;
    return h;
  endfunction

  function automatic logic [HWB-1:0] drop(input logic [HWB-1:0] h, input int c, input int j);
    h[(c*NP + j)*2 +: 2] = 2'b00;
    return h;
  endfunction

  task automatic check(input string tag, input logic [NC*12-1:0] act, input logic [NC*12-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag);
    check({tag, " inner"}, out_i, exp_i);
    check({tag, " outer"}, out_o, exp_o);
  endtask

  task automatic crossing(input logic [HWB-1:0] h, input int t, input string tag);
    @(negedge clk);
    cmp("R8 hold before strobe");
    hits = h; tol = 2'(t); xing = 1;
    @(posedge clk);
    #1;
    exp_i = nxt_i; exp_o = nxt_o; tag_cur = tag_nxt;
    nxt_i = model(h, t, 1'b0); nxt_o = model(h, t, 1'b1); tag_nxt = tag;
    @(negedge clk);
    xing = 0;
    cmp({tag_cur, " R8 update"});
    hits = {$urandom, $urandom, $urandom, $urandom};
    tol = 2'($urandom);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmp({tag_cur, " R7 R8"});
    end
  endtask

  logic [HWB-1:0] h;
  bit done = 0;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset inner", out_i, '0);
    check("R1 reset outer", out_o, '0);
    rst = 0;
    crossing({HWB{1'b1}}, 0, "R1 R5 R6 all hits");
    h = put('0, 0, 0); h = put(h, 1, 3); h = put(h, 3, 7);
    crossing(h, 0, "R3 R4 exact and neighbour");
    crossing(drop(put('0, 0, 0), 0, 5), 0, "R2 one miss tol0");
    crossing(drop(put('0, 0, 0), 0, 5), 1, "R2 one miss tol1");
    h = put('0, 0, 2); h = drop(drop(drop(h, 0, 1), 0, 4), 0, 9);
    h = put(h, 1, 2); h = drop(drop(drop(drop(h, 1, 1), 1, 4), 1, 9), 1, 11);
    crossing(h, 3, "R2 three vs four misses");
    h = put('0, 0, 2); h = put(h, 0, 6); h = put(h, 1, 0); h = put(h, 1, 1); h = put(h, 1, 4);
    crossing(h, 0, "R5 R6 shared pixel priority");
    h = put('0, 0, 1); h = put(h, 1, 5); h = put(h, 2, 7); h = put(h, 3, 3);
    crossing(h, 0, "R7 one mask per cell");
    h = put('0, 3, 5); h = put(h, 3, 3);
    crossing(h, 1, "R3 spare neighbour cell");
    for (int n = 0; n < 24; n++) begin
      h = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      for (int c = 0; c < NC; c++) h = put(h, c, int'($urandom % NM));
      for (int d = 0; d < 4; d++) h = drop(h, int'($urandom % NC), int'($urandom % NP));
      crossing(h, int'($urandom % 4), "R2 R4 R5 R6 random");
    end
    crossing('0, 0, "R4 empty");
    crossing('0, 0, "R8 flush");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule